// File: doc/BRIEF.md
# Coprocessor Instruction Queue Tracker

This block sits inside a coprocessor that shares a bus with a host CPU. The host prefetches instruction bytes into a six-byte queue, and the coprocessor cannot see that queue directly. The block therefore keeps its own copy. It records every byte that appears on the data bus during an instruction-fetch cycle. It then follows the host's 2-bit queue-status code, so that its copy is popped and flushed at the same points as the host's queue.

Each byte that the host takes as the first byte of an instruction is tested against the escape prefix, which is a match of its five most significant bits with 11011. When the first byte matches, the block keeps it. It also keeps the next subsequent-byte pop of the same instruction as the second opcode byte, and it then raises a one-cycle detection pulse. The coprocessor's execution logic uses the pulse and the two captured bytes. A host flush is reported as a one-cycle pulse. A pop of the copy while it is empty is recorded as a sticky error.

Top module: `escQueueMirror`

## Requirements
- R1: While reset is low and in the first cycle after it is released, escPulse, flushSeen and popError are 0, both opcode outputs are 0x00, and the queue copy holds no bytes.
- R2: When fetchStrobe is high, the busData byte is appended at the tail of the queue copy, which holds at most 6 bytes. Pops take bytes out in arrival order. A fetch into a full copy in a cycle with no pop is dropped.
- R3: The status code 2'b00 (idle) changes nothing. The opcode outputs and all flags hold, and the queued bytes stay in place for later pops.
- R4: The status code 2'b01 (first byte taken) pops the head byte. If bits [7:3] of that byte equal 5'b11011, the byte appears on escOpcode0 one cycle later and an escape becomes pending. If they differ, the byte is discarded and any pending escape ends.
- R5: The status code 2'b11 (subsequent byte taken) pops the head byte. If an escape is pending, the byte appears on escOpcode1 one cycle later, escPulse is high for exactly that one cycle, and the escape is no longer pending. With no escape pending, the byte is discarded and neither opcode output changes.
- R6: The status code 2'b10 (flush) empties the queue copy, cancels a pending escape, and drops any fetch in the same cycle. flushSeen is high for exactly the one cycle that follows.
- R7: A fetch and a pop in the same cycle are both carried out, and this holds even when the copy is full.
- R8: A pop with status 2'b01 or 2'b11 while the copy is empty leaves the copy unchanged and sets popError. popError then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fetchStrobe | input | 1 | High in a cycle where busData carries a fetched instruction byte |
| busData | input | 8 | Host data bus |
| qStat | input | 2 | Host queue-status code: 00 idle, 01 first byte, 10 flush, 11 subsequent byte |
| escPulse | output | 1 | One-cycle pulse when the second escape opcode byte is captured |
| escOpcode0 | output | 8 | Last escape first byte captured |
| escOpcode1 | output | 8 | Last escape second byte captured |
| flushSeen | output | 1 | One-cycle pulse after a host flush |
| popError | output | 1 | Sticky flag for a pop of the empty copy |

## Verification
The assertions assume only that qStat and fetchStrobe hold known values at every clock edge after reset. They do not assume that the host behaves consistently: pops of an empty copy, fetches into a full copy, and flushes in the middle of an escape are all legal input. The random stimulus draws every status code, including flushes at a lower rate, with a fetch in about half of the cycles and escape-prefixed bytes in about half of the fetches. All inputs are always driven to defined values, and the random run therefore stays inside what the assertions take for granted. It still reaches the empty-pop, full-push and cancelled-escape cases.

// File: rtl/fqmPkg.sv
package fqmPkg;

  typedef enum logic [1:0] {
    QIDLE  = 2'b00,
    QFIRST = 2'b01,
    QFLUSH = 2'b10,
    QLATER = 2'b11
  } qCode_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
    logic takeFirst;
    logic takeSecond;
  } qStrobe_t;

endpackage

// File: rtl/fqmDatapath.sv
module fqmDatapath
  import fqmPkg::*;
#(
  parameter int DEPTH = 6,
  parameter int WIDTH = 8,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  qStrobe_t         strobe,
  input  logic [WIDTH-1:0] busData,
  output logic [WIDTH-1:0] headByte,
  output logic             empty,
  output logic             full,
  output logic [CNTW-1:0]  fillLevel,
  output logic [WIDTH-1:0] opFirst,
  output logic [WIDTH-1:0] opSecond
);

  localparam logic [PTRW-1:0] LAST_PTR = PTRW'(DEPTH - 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  logic [WIDTH-1:0] slot [DEPTH];
  logic [PTRW-1:0]  rdPtr, wrPtr;
  logic [CNTW-1:0]  count;

  function automatic logic [PTRW-1:0] advance(input logic [PTRW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTRW'(1);
  endfunction

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (strobe.push && (wrPtr == PTRW'(i))) slot[i] <= busData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (strobe.clear) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= advance(wrPtr);
      if (strobe.pop)  rdPtr <= advance(rdPtr);
      count <= count + CNTW'(strobe.push) - CNTW'(strobe.pop);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opFirst  <= '0;
      opSecond <= '0;
    end else begin
      if (strobe.takeFirst)  opFirst  <= headByte;
      if (strobe.takeSecond) opSecond <= headByte;
    end
  end

  assign headByte  = slot[rdPtr];
  assign empty     = (count == '0);
  assign full      = (count == FULL_CNT);
  assign fillLevel = count;

endmodule

// File: rtl/fqmControl.sv
module fqmControl
  import fqmPkg::*;
#(
  parameter int WIDTH = 8,
  parameter int PREFIX_BITS = 5,
  parameter logic [PREFIX_BITS-1:0] ESC_PREFIX = 5'b11011
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       qStat,
  input  logic             fetchStrobe,
  input  logic [WIDTH-1:0] headByte,
  input  logic             empty,
  input  logic             full,
  output qStrobe_t         strobe,
  output logic             escPulse,
  output logic             flushSeen,
  output logic             popError
);

  qCode_t code;
  logic   popReq, flushReq, isEscHead, pending;

  assign code = qCode_t'(qStat);

  always_comb begin
    popReq    = (code == QFIRST) || (code == QLATER);
    flushReq  = (code == QFLUSH);
    isEscHead = (headByte[WIDTH-1 -: PREFIX_BITS] == ESC_PREFIX);
    strobe.clear      = flushReq;
    strobe.pop        = popReq && !empty;
    strobe.push       = fetchStrobe && !flushReq && (!full || strobe.pop);
    strobe.takeFirst  = strobe.pop && (code == QFIRST) && isEscHead;
    strobe.takeSecond = strobe.pop && (code == QLATER) && pending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= 1'b0;
      escPulse  <= 1'b0;
      flushSeen <= 1'b0;
      popError  <= 1'b0;
    end else begin
      escPulse  <= strobe.takeSecond;
      flushSeen <= flushReq;
      if (popReq && empty) popError <= 1'b1;
      if (flushReq)                             pending <= 1'b0;
      else if (strobe.pop && code == QFIRST)    pending <= isEscHead;
      else if (strobe.takeSecond)               pending <= 1'b0;
    end
  end

endmodule

// File: rtl/escQueueMirror.sv
module escQueueMirror
  import fqmPkg::*;
#(
  parameter int DEPTH = 6,
  parameter int WIDTH = 8,
  parameter int PREFIX_BITS = 5,
  parameter logic [PREFIX_BITS-1:0] ESC_PREFIX = 5'b11011,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchStrobe,
  input  logic [WIDTH-1:0] busData,
  input  logic [1:0]       qStat,
  output logic             escPulse,
  output logic [WIDTH-1:0] escOpcode0,
  output logic [WIDTH-1:0] escOpcode1,
  output logic             flushSeen,
  output logic             popError
);

  qStrobe_t         strobe;
  logic [WIDTH-1:0] headByte;
  logic             empty, full;
  logic [CNTW-1:0]  fillLevel;

  fqmControl #(
    .WIDTH(WIDTH), .PREFIX_BITS(PREFIX_BITS), .ESC_PREFIX(ESC_PREFIX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .qStat(qStat), .fetchStrobe(fetchStrobe),
    .headByte(headByte), .empty(empty), .full(full), .strobe(strobe),
    .escPulse(escPulse), .flushSeen(flushSeen), .popError(popError)
  );

  fqmDatapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busData(busData),
    .headByte(headByte), .empty(empty), .full(full), .fillLevel(fillLevel),
    .opFirst(escOpcode0), .opSecond(escOpcode1)
  );

endmodule

// File: rtl/fqmChecker.sv
module fqmChecker #(
  parameter int DEPTH = 6,
  parameter int WIDTH = 8,
  parameter int CNTW = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       qStat,
  input logic             fetchStrobe,
  input logic             escPulse,
  input logic [WIDTH-1:0] escOpcode0,
  input logic             popError,
  input logic [CNTW-1:0]  fillLevel
);

  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(fillLevel) <= DEPTH);

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    qStat == 2'b10 |=> fillLevel == '0);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    popError |=> popError);

  // R5
  esc_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    escPulse |=> !escPulse);

  // R5
  esc_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    escPulse |-> $past(qStat) == 2'b11);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qStat == 2'b00 && !fetchStrobe) |=> $stable(fillLevel));

  // R4
  op0_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    qStat != 2'b01 |=> $stable(escOpcode0));

endmodule

bind escQueueMirror fqmChecker #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNTW(CNTW)) u_chk (
  .clk(clk), .rstN(rstN), .qStat(qStat), .fetchStrobe(fetchStrobe),
  .escPulse(escPulse), .escOpcode0(escOpcode0), .popError(popError),
  .fillLevel(fillLevel)
);

// File: tb/escQueueMirror_tb.sv
module escQueueMirror_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fetchStrobe = 1'b0;
  logic [7:0] busData = 8'h00;
  logic [1:0] qStat = 2'b00;
  logic       escPulse, flushSeen, popError;
  logic [7:0] escOpcode0, escOpcode1;

  int total = 0;
  int bad = 0;
  string phaseTag = "R1";

  // bench model
  logic [7:0] mq [6];
  int         mCnt;
  logic       mPend, mPulse, mFlush, mErr;
  logic [7:0] mOp0, mOp1;

  always #2 clk = ~clk;

  escQueueMirror u_dut (
    .clk(clk), .rstN(rstN), .fetchStrobe(fetchStrobe), .busData(busData),
    .qStat(qStat), .escPulse(escPulse), .escOpcode0(escOpcode0),
    .escOpcode1(escOpcode1), .flushSeen(flushSeen), .popError(popError)
  );

  function automatic bit isEsc(input logic [7:0] b);
    return b[7:3] == 5'b11011;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s (%s) actual=%h expected=%h", tag, phaseTag, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R5 escPulse",   {7'b0, escPulse},  {7'b0, mPulse});
    chk("R4 escOpcode0", escOpcode0, mOp0);
    chk("R5 escOpcode1", escOpcode1, mOp1);
    chk("R6 flushSeen",  {7'b0, flushSeen}, {7'b0, mFlush});
    chk("R8 popError",   {7'b0, popError},  {7'b0, mErr});
  endtask

  task automatic modelReset();
    mCnt = 0; mPend = 0; mPulse = 0; mFlush = 0; mErr = 0; mOp0 = 0; mOp1 = 0;
    for (int i = 0; i < 6; i++) mq[i] = 8'h00;
  endtask

  task automatic modelStep(input logic [1:0] q, input logic f, input logic [7:0] d);
    logic [7:0] h;
    mPulse = 0;
    mFlush = (q == 2'b10);
    if (q == 2'b10) begin
      mCnt = 0; mPend = 0;
    end else begin
      if (q[0]) begin
        if (mCnt == 0) mErr = 1;
        else begin
          h = mq[0];
          for (int i = 0; i < 5; i++) mq[i] = mq[i+1];
          mCnt--;
          if (q == 2'b01) begin
            mPend = isEsc(h);
            if (isEsc(h)) mOp0 = h;
          end else if (mPend) begin
            mOp1 = h; mPulse = 1; mPend = 0;
          end
        end
      end
      if (f && mCnt < 6) begin
        mq[mCnt] = d; mCnt++;
      end
    end
  endtask

  task automatic step(input logic [1:0] q, input logic f, input logic [7:0] d);
    @(negedge clk);
    compareAll();
    qStat = q; fetchStrobe = f; busData = d;
    modelStep(q, f, d);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; qStat = 2'b00; fetchStrobe = 0; busData = 8'h00;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();

    // R1 reset state
    phaseTag = "R1";
    doReset();
    step(2'b00, 0, 8'h00);
    step(2'b00, 0, 8'h00);

    // R8 pop on empty, sticky
    phaseTag = "R8";
    step(2'b01, 0, 8'h00);
    step(2'b00, 0, 8'h00);
    step(2'b11, 0, 8'h00);
    step(2'b00, 0, 8'h00);

    // R2 arrival order, full drop
    phaseTag = "R2";
    doReset();
    for (int i = 0; i < 6; i++) step(2'b00, 1, 8'hD8 + 8'(i));
    step(2'b00, 1, 8'hDE);
    for (int i = 0; i < 6; i++) step(2'b01, 0, 8'h00);
    step(2'b01, 0, 8'h00);
    step(2'b00, 0, 8'h00);

    // R7 push and pop together on a full copy
    phaseTag = "R7";
    doReset();
    for (int i = 0; i < 6; i++) step(2'b00, 1, 8'hD0 + 8'(i));
    step(2'b01, 1, 8'hD6);
    for (int i = 0; i < 6; i++) step(2'b01, 0, 8'h00);
    step(2'b01, 0, 8'h00);
    step(2'b00, 0, 8'h00);

    // R5 escape capture, trailing byte ignored, non-escape ignored
    phaseTag = "R5";
    doReset();
    step(2'b00, 1, 8'hD9);
    step(2'b00, 1, 8'h3A);
    step(2'b00, 1, 8'h7C);
    step(2'b01, 0, 8'h00);
    step(2'b11, 0, 8'h00);
    step(2'b11, 0, 8'h00);
    step(2'b00, 1, 8'h12);
    step(2'b00, 1, 8'h34);
    step(2'b01, 0, 8'h00);
    step(2'b11, 0, 8'h00);
    step(2'b00, 0, 8'h00);

    // R6 flush cancels pending escape and drops same-cycle fetch
    phaseTag = "R6";
    step(2'b00, 1, 8'hDA);
    step(2'b00, 1, 8'h55);
    step(2'b01, 0, 8'h00);
    step(2'b10, 1, 8'h66);
    step(2'b00, 1, 8'h77);
    step(2'b11, 0, 8'h00);
    step(2'b11, 0, 8'h00);
    step(2'b00, 0, 8'h00);

    // R3 idle cycles keep queued data
    phaseTag = "R3";
    doReset();
    step(2'b00, 1, 8'hDB);
    step(2'b00, 0, 8'h00);
    step(2'b00, 0, 8'h00);
    step(2'b00, 0, 8'h00);
    step(2'b01, 0, 8'h00);
    step(2'b00, 0, 8'h00);

    // random mix over all requirements
    phaseTag = "RND";
    doReset();
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [1:0] q;
      logic [7:0] d;
      r = int'($urandom % 10);
      q = (r < 3) ? 2'b00 : (r < 6) ? 2'b01 : (r < 9) ? 2'b11 : 2'b10;
      d = 8'($urandom);
      if ($urandom % 2 == 0) d[7:3] = 5'b11011;
      step(q, 1'($urandom % 2), d);
      if (n == 1500) begin
        doReset();
      end
    end
    step(2'b00, 0, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule